// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an up/down counter with one compare channel and a waveform generator that drives a single output pin. It advances on a one-cycle `tick` enable produced by an external prescaler, and only while its clock-select field is non-zero. Four waveform modes are available: a free-running counter, a counter that clears on compare, a single-slope PWM and a dual-slope (phase-correct) PWM. In the two PWM modes the dual-slope variant applies different pin actions on the up and down slopes. In those modes the compare value is double buffered, so the pulse width changes only at a period boundary.

Software reaches the block through separate write strobes for the count, the compare value, the control byte and the interrupt mask. It reads back the count, the compare value and the control byte. A write-one-to-clear vector clears the status flags. An overflow flag and a compare flag latch events, and `irq` combines them with the mask. A force-compare bit in the control byte applies the selected pin action at once. It does this only in non-PWM modes, and it never raises a flag or moves the counter.

Top module: `tmr8_wavegen`

## Requirements
- R1: After reset the count, compare value, control byte, both flags, the mask, `oc_pin` and `irq` are all zero.
- R2: The count holds while `tick` is low or the clock-select field is zero. A count write loads the value on the next edge and takes priority over counting.
- R3: In normal mode (mode 0) the count goes up by one on each enabled tick and wraps from 255 to 0.
- R4: The overflow flag sets on the tick that takes the count from 255 to 0 in modes 0, 2 and 3. In mode 1 it sets on the tick that brings the count down to 0. It stays set until `flag_clr[0]` is written as one, and a new event takes priority over a clear in the same cycle.
- R5: The compare flag sets on every tick where the count equals the active compare value, and `flag_clr[1]` clears it. `irq` is high when any flag is set together with its mask bit (mask bit 0 for overflow, mask bit 1 for compare).
- R6: In clear-on-compare mode (mode 2) the count returns to 0 on the tick after it equals the compare value, which gives a period of compare+1 ticks. In modes 0 and 2 a compare write takes effect at once.
- R7: In modes 0 and 2 the output-mode field acts on a compare match as follows: 00 disconnects the pin (`oc_pin` low), 01 toggles it, 10 clears it and 11 sets it.
- R8: A count write suppresses the compare match on the first tick after it. That tick sets no flag, takes no pin action and does no clear-on-compare.
- R9: Writing control bit 7 as one in mode 0 or 2 applies the written output-mode action to the pin on that edge. It sets no flag, leaves the count unchanged and always reads back as zero. In modes 1 and 3 the bit has no effect.
- R10: In fast PWM (mode 3) the count runs 0..255 and repeats. With output mode 10 the pin is high for compare+1 of every 256 ticks. With 11 it is high for the remaining ticks. With 01 the pin stays low.
- R11: In phase-correct PWM (mode 1) the count runs 0→255→0 with a period of 510 ticks. With output mode 10 the pin clears on an up-slope match and sets on a down-slope match, so it is high for 2×compare of 510 ticks; 11 inverts this. The compare flag sets twice per period, or once when compare is 0 or 255.
- R12: In modes 1 and 3 a compare write updates the readback at once, but the active compare value only picks it up on the tick where the count is 255.
- R13: Control byte layout: bits 1:0 select the mode (0 normal, 1 phase-correct, 2 clear-on-compare, 3 fast PWM), bits 3:2 select the output mode, bits 6:4 select the clock (zero stops the counter) and bit 7 is the force strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| flag_clr | input | 2 | Write-one-to-clear (bit 0 overflow, bit 1 compare) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 2 | Mask write value |
| count_q | output | CNT_W | Current count |
| cmp_rd | output | CNT_W | Compare value as written |
| ctl_rd | output | 8 | Control byte readback, bit 7 always zero |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| oc_pin | output | 1 | Waveform output |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sweeps compare values that include 0, 1, 254 and 255 in both PWM modes and both polarities, and counts high ticks over a full period. A wrong priority between the match and bottom actions would show up at compare 255 as a lost one-tick pulse, and a wrong slope choice at the turnaround would invert the result at compare 0 and 255. Flag events are counted over exact multiples of the period, so a missed turnaround match or a doubled overflow changes the tally. A count write placed on the compare value shows whether the blocked match still clears the counter. Forcing while the counter is stopped exposes a force that leaks into the flag or the count, and a force in PWM mode exposes one that is not gated.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic [1:0] {
      WM_NORMAL = 2'd0,
      WM_PHASE  = 2'd1,
      WM_CTC    = 2'd2,
      WM_FAST   = 2'd3
   } wave_mode_e;

   typedef enum logic [1:0] {
      OM_OFF    = 2'd0,
      OM_TOGGLE = 2'd1,
      OM_CLEAR  = 2'd2,
      OM_SET    = 2'd3
   } out_mode_e;

   typedef struct packed {
      logic       frc;
      logic [2:0] clk_sel;
      out_mode_e  om;
      wave_mode_e wm;
   } ctl_t;

   function automatic logic mode_is_pwm(input wave_mode_e m);
      return (m == WM_PHASE) || (m == WM_FAST);
   endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  wave_mode_e       mode,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             hit,
   output logic [CNT_W-1:0] cnt,
   output logic             rising,
   output logic             at_max,
   output logic             ovf_evt
);

   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic             dir_up;
   logic             dir_nxt;
   logic [CNT_W-1:0] cnt_nxt;

   assign at_max = (cnt == MAXV);

   always_comb begin
      cnt_nxt = cnt + ONE;
      dir_nxt = 1'b1;
      unique case (mode)
         WM_CTC: begin
            if (hit) cnt_nxt = ZERO;
         end
         WM_PHASE: begin
            if (dir_up) begin
               if (at_max) begin
                  cnt_nxt = MAXV - ONE;
                  dir_nxt = 1'b0;
               end else begin
                  dir_nxt = 1'b1;
               end
            end else begin
               if (cnt == ZERO) begin
                  cnt_nxt = ONE;
                  dir_nxt = 1'b1;
               end else begin
                  cnt_nxt = cnt - ONE;
                  dir_nxt = 1'b0;
               end
            end
         end
         default: begin
            cnt_nxt = cnt + ONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= ZERO;
         dir_up <= 1'b1;
      end else begin
         if (ld)       cnt <= ld_val;
         else if (adv) cnt <= cnt_nxt;

         if (mode != WM_PHASE)  dir_up <= 1'b1;
         else if (!ld && adv)   dir_up <= dir_nxt;
      end
   end

   assign rising = (mode != WM_PHASE) ? 1'b1 :
                   ((dir_up && !at_max) || (!dir_up && (cnt == ZERO)));

   assign ovf_evt = adv && !ld &&
                    ((mode == WM_PHASE) ? (!dir_up && (cnt == ONE)) : at_max);

endmodule

// File: rtl/tmr8_compare.sv
module tmr8_compare #(
   parameter int CNT_W    = 8,
   parameter bit BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             pwm,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             ld_cnt,
   input  logic             at_max,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] buf_q,
   output logic [CNT_W-1:0] act_q,
   output logic             hit
);

   logic blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_q <= 1'b0;
      else if (ld_cnt) blk_q <= 1'b1;
      else if (adv)    blk_q <= 1'b0;
   end

   assign hit = adv && !ld_cnt && !blk_q && (cnt == act_q);

   generate
      if (BUFFERED) begin : g_dbl
         logic [CNT_W-1:0] shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               act_q    <= '0;
            end else begin
               if (wr) shadow_q <= wdata;
               if (!pwm)                          act_q <= wr ? wdata : shadow_q;
               else if (adv && at_max && !ld_cnt) act_q <= shadow_q;
            end
         end
         assign buf_q = shadow_q;
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  act_q <= '0;
            else if (wr) act_q <= wdata;
         end
         assign buf_q = act_q;
      end
   endgenerate

endmodule

// File: rtl/tmr8_wave_unit.sv
module tmr8_wave_unit
   import tmr8_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wave_mode_e mode,
   input  out_mode_e  om,
   input  logic       hit,
   input  logic       rising,
   input  logic       top_evt,
   input  logic       frc,
   input  out_mode_e  frc_om,
   output logic       pin_q
);

   logic do_set, do_clr, do_tgl;

   always_comb begin
      do_set = 1'b0;
      do_clr = 1'b0;
      do_tgl = 1'b0;
      unique case (mode)
         WM_FAST: begin
            if (om == OM_CLEAR) begin
               if (hit)     do_clr = 1'b1;
               if (top_evt) begin do_set = 1'b1; do_clr = 1'b0; end
            end else if (om == OM_SET) begin
               if (hit)     do_set = 1'b1;
               if (top_evt) begin do_clr = 1'b1; do_set = 1'b0; end
            end
         end
         WM_PHASE: begin
            if (hit && (om == OM_CLEAR)) begin
               do_clr = rising;
               do_set = !rising;
            end else if (hit && (om == OM_SET)) begin
               do_set = rising;
               do_clr = !rising;
            end
         end
         default: begin
            if (hit) begin
               do_tgl = (om == OM_TOGGLE);
               do_clr = (om == OM_CLEAR);
               do_set = (om == OM_SET);
            end
         end
      endcase
      if (frc) begin
         do_tgl = (frc_om == OM_TOGGLE);
         do_clr = (frc_om == OM_CLEAR);
         do_set = (frc_om == OM_SET);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pin_q <= 1'b0;
      else if (do_set) pin_q <= 1'b1;
      else if (do_clr) pin_q <= 1'b0;
      else if (do_tgl) pin_q <= ~pin_q;
   end

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
   import tmr8_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter bit CMP_BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   input  logic [1:0]       flag_clr,
   input  logic             mask_wr,
   input  logic [1:0]       mask_wdata,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] cmp_rd,
   output logic [7:0]       ctl_rd,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             oc_pin,
   output logic             irq
);

   localparam int NFLAG    = 2;
   localparam int FLAG_OVF = 0;
   localparam int FLAG_CMP = 1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr8_wavegen: CNT_W must be at least 2");
      end
   endgenerate

   ctl_t ctl_q;
   ctl_t ctl_in;
   logic adv, pwm, frc_evt;
   logic rising, at_max, ovf_evt, hit, pin_q, connected;
   logic [CNT_W-1:0] act_cmp;
   logic [NFLAG-1:0] flag_set, flag_q, mask_q;

   assign ctl_in = ctl_t'(ctl_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q     <= ctl_in;
         ctl_q.frc <= 1'b0;
      end
   end

   assign ctl_rd  = ctl_q;
   assign adv     = tick && (ctl_q.clk_sel != 3'd0);
   assign pwm     = mode_is_pwm(ctl_q.wm);
   assign frc_evt = ctl_wr && ctl_in.frc && !mode_is_pwm(ctl_in.wm);

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .mode    (ctl_q.wm),
      .ld      (cnt_wr),
      .ld_val  (cnt_wdata),
      .hit     (hit),
      .cnt     (count_q),
      .rising  (rising),
      .at_max  (at_max),
      .ovf_evt (ovf_evt)
   );

   tmr8_compare #(.CNT_W(CNT_W), .BUFFERED(CMP_BUFFERED)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .pwm    (pwm),
      .wr     (cmp_wr),
      .wdata  (cmp_wdata),
      .ld_cnt (cnt_wr),
      .at_max (at_max),
      .cnt    (count_q),
      .buf_q  (cmp_rd),
      .act_q  (act_cmp),
      .hit    (hit)
   );

   tmr8_wave_unit u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (ctl_q.wm),
      .om      (ctl_q.om),
      .hit     (hit),
      .rising  (rising),
      .top_evt (adv && at_max && !cnt_wr),
      .frc     (frc_evt),
      .frc_om  (ctl_in.om),
      .pin_q   (pin_q)
   );

   assign connected = (ctl_q.om != OM_OFF) && !(pwm && (ctl_q.om == OM_TOGGLE));
   assign oc_pin    = pin_q && connected;

   assign flag_set[FLAG_OVF] = ovf_evt;
   assign flag_set[FLAG_CMP] = hit;

   genvar g;
   generate
      for (g = 0; g < NFLAG; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_q[g] <= 1'b0;
            else if (flag_set[g]) flag_q[g] <= 1'b1;
            else if (flag_clr[g]) flag_q[g] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   assign ovf_flag = flag_q[FLAG_OVF];
   assign cmp_flag = flag_q[FLAG_CMP];
   assign irq      = |(flag_q & mask_q);

   logic unused_act;
   assign unused_act = ^act_cmp;

endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             cnt_wr,
   input logic             ctl_wr,
   input logic [7:0]       ctl_wdata,
   input logic [1:0]       flag_clr,
   input logic [CNT_W-1:0] count_q,
   input logic [7:0]       ctl_rd,
   input logic             ovf_flag,
   input logic             cmp_flag
);

   logic run;
   assign run = tick && (ctl_rd[6:4] != 3'd0);

   // R2
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && !run) |=> $stable(count_q));

   // R3
   norm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (ctl_rd[1:0] == 2'd0) && !cnt_wr)
      |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

   // R4
   norm_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (ctl_rd[1:0] == 2'd0) && !cnt_wr && (&count_q)) |=> ovf_flag);

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr[0]) |=> ovf_flag);

   // R9
   force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[7] && !tick && !cmp_flag) |=> !cmp_flag);

endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr8_wavegen.sv
module tb_tmr8_wavegen;

   localparam int W = 8;
   localparam int NV = 11;
   localparam int OCRS [NV] = '{0, 1, 2, 3, 64, 127, 128, 200, 253, 254, 255};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b1;
   logic         cnt_wr = 1'b0;
   logic [W-1:0] cnt_wdata = '0;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         ctl_wr = 1'b0;
   logic [7:0]   ctl_wdata = '0;
   logic [1:0]   flag_clr = '0;
   logic         mask_wr = 1'b0;
   logic [1:0]   mask_wdata = '0;
   logic [W-1:0] count_q, cmp_rd;
   logic [7:0]   ctl_rd;
   logic         ovf_flag, cmp_flag, oc_pin, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr8_wavegen dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input int m, input int om, input int cs, input bit frc);
      ctl_wr = 1'b1;
      ctl_wdata = {frc, 3'(cs), 2'(om), 2'(m)};
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_cnt(input int v);
      cnt_wr = 1'b1; cnt_wdata = W'(v);
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic wr_cmp(input int v);
      cmp_wr = 1'b1; cmp_wdata = W'(v);
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   task automatic w1c(input logic [1:0] v);
      flag_clr = v;
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic wr_mask(input logic [1:0] v);
      mask_wr = 1'b1; mask_wdata = v;
      @(negedge clk);
      mask_wr = 1'b0;
   endtask

   task automatic wait_cnt(input int v, input string tag);
      int guard = 0;
      while (int'(count_q) != v && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk({tag, " reach count"}, int'(count_q), v);
   endtask

   task automatic ev_count(input int n, output int n_ovf, output int n_cmp);
      n_ovf = 0; n_cmp = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         n_ovf += int'(ovf_flag);
         n_cmp += int'(cmp_flag);
         flag_clr = {cmp_flag, ovf_flag};
      end
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic run_duty(input int m, input int om, input int ocr, input int per,
                           input int exp, input string tag);
      int hi = 0;
      wr_ctl(m, om, 1, 1'b0);
      wr_cmp(ocr);
      repeat (2 * per + 4) @(negedge clk);
      for (int i = 0; i < per; i++) begin
         @(negedge clk);
         hi += int'(oc_pin);
      end
      chk($sformatf("%s ocr=%0d om=%0d high ticks", tag, ocr, om), hi, exp);
   endtask

   initial begin
      int n_o, n_c, prev, tg, c0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 count", int'(count_q), 0);
      chk("R1 cmp_rd", int'(cmp_rd), 0);
      chk("R1 ctl_rd", int'(ctl_rd), 0);
      chk("R1 flags", int'({ovf_flag, cmp_flag}), 0);
      chk("R1 pin/irq", int'({oc_pin, irq}), 0);
      rst_n = 1'b1;

      // R2 hold with clock select zero, load on write
      repeat (20) @(negedge clk);
      chk("R2 cs=0 hold", int'(count_q), 0);
      wr_cnt(77);
      chk("R2 load", int'(count_q), 77);
      repeat (10) @(negedge clk);
      chk("R2 hold after load", int'(count_q), 77);
      tick = 1'b0;
      wr_ctl(0, 0, 1, 1'b0);
      chk("R13 ctl readback", int'(ctl_rd), 8'h10);
      repeat (10) @(negedge clk);
      chk("R2 tick low hold", int'(count_q), 77);
      tick = 1'b1;

      // R3 / R4 normal counting and overflow
      wr_cnt(250);
      chk("R2 write wins", int'(count_q), 250);
      for (int i = 1; i <= 7; i++) begin
         int e;
         @(negedge clk);
         e = (250 + i) % 256;
         chk("R3 normal step", int'(count_q), e);
         if (e == 255) chk("R4 ovf before wrap", int'(ovf_flag), 0);
         if (e == 0)   chk("R4 ovf at wrap", int'(ovf_flag), 1);
      end
      repeat (300) @(negedge clk);
      chk("R4 ovf sticky", int'(ovf_flag), 1);
      w1c(2'b01);
      chk("R4 ovf cleared", int'(ovf_flag), 0);

      // R5 interrupt masking
      wr_mask(2'b01);
      wait_cnt(0, "R5");
      chk("R5 irq ovf masked in", int'(irq), 1);
      wr_mask(2'b00);
      chk("R5 irq masked out", int'({ovf_flag, irq}), 2);
      w1c(2'b11);
      wr_mask(2'b10);
      wait_cnt(1, "R5");
      chk("R5 cmp flag at match", int'(cmp_flag), 1);
      chk("R5 irq from cmp", int'(irq), 1);
      wr_mask(2'b00);

      // R6 clear on compare
      wr_ctl(2, 0, 1, 1'b0);
      wr_cmp(5);
      chk("R6 cmp readback", int'(cmp_rd), 5);
      wr_cnt(0);
      chk("R6 start", int'(count_q), 0);
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         chk("R6 ctc sequence", int'(count_q), i % 6);
      end
      wr_ctl(2, 0, 0, 1'b0);
      w1c(2'b11);
      wr_ctl(2, 0, 1, 1'b0);
      ev_count(60, n_o, n_c);
      chk("R6 ctc matches in 60", n_c, 10);
      chk("R4 no ovf in ctc", n_o, 0);
      chk("R7 disconnected pin", int'(oc_pin), 0);

      // R7 toggle / clear / set
      wr_ctl(2, 1, 1, 1'b0);
      prev = int'(oc_pin); tg = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (int'(oc_pin) != prev) tg++;
         prev = int'(oc_pin);
      end
      chk("R7 toggles in 60", tg, 10);
      wr_ctl(2, 2, 1, 1'b0);
      repeat (12) @(negedge clk);
      chk("R7 clear on match", int'(oc_pin), 0);
      wr_ctl(2, 3, 1, 1'b0);
      repeat (12) @(negedge clk);
      chk("R7 set on match", int'(oc_pin), 1);

      // R8 count write blocks next match
      wr_cnt(5);
      chk("R8 loaded", int'(count_q), 5);
      w1c(2'b10);
      chk("R8 no ctc clear", int'(count_q), 6);
      chk("R8 no flag", int'(cmp_flag), 0);

      // R9 force strobe
      wr_ctl(2, 3, 0, 1'b0);
      w1c(2'b11);
      c0 = int'(count_q);
      wr_ctl(2, 2, 0, 1'b1);
      chk("R9 force clear", int'(oc_pin), 0);
      wr_ctl(2, 3, 0, 1'b1);
      chk("R9 force set", int'(oc_pin), 1);
      chk("R9 no flag", int'(cmp_flag), 0);
      chk("R9 count kept", int'(count_q), c0);
      chk("R9 reads zero", int'(ctl_rd[7]), 0);
      wr_ctl(3, 2, 0, 1'b1);
      chk("R9 ignored in pwm", int'(oc_pin), 1);
      wr_ctl(0, 1, 0, 1'b1);
      chk("R9 force toggle", int'(oc_pin), 0);

      // R10 fast PWM sweeps
      for (int i = 0; i < NV; i++) begin
         run_duty(3, 2, OCRS[i], 256, OCRS[i] + 1, "R10 fast");
         run_duty(3, 3, OCRS[i], 256, 255 - OCRS[i], "R10 fast inv");
      end
      run_duty(3, 1, 100, 256, 0, "R10 fast om01");
      wr_ctl(3, 2, 0, 1'b0);
      w1c(2'b11);
      wr_ctl(3, 2, 1, 1'b0);
      ev_count(512, n_o, n_c);
      chk("R10 fast ovf per 2 periods", n_o, 2);
      chk("R10 fast cmp per 2 periods", n_c, 2);

      // R12 double buffering
      wr_ctl(3, 2, 1, 1'b0);
      wr_cmp(200);
      repeat (600) @(negedge clk);
      wait_cnt(50, "R12");
      wr_cmp(10);
      chk("R12 readback now", int'(cmp_rd), 10);
      wait_cnt(100, "R12");
      chk("R12 old value active", int'(oc_pin), 1);
      wait_cnt(20, "R12");
      chk("R12 new value after top", int'(oc_pin), 0);

      // R11 phase-correct
      for (int i = 0; i < NV; i++) begin
         run_duty(1, 2, OCRS[i], 510, 2 * OCRS[i], "R11 pc");
         run_duty(1, 3, OCRS[i], 510, 510 - 2 * OCRS[i], "R11 pc inv");
      end
      wait_cnt(255, "R11");
      @(negedge clk);
      chk("R11 turn down", int'(count_q), 254);
      @(negedge clk);
      chk("R11 keep down", int'(count_q), 253);
      wait_cnt(0, "R11");
      @(negedge clk);
      chk("R11 turn up", int'(count_q), 1);
      foreach (OCRS[k]) begin
         if (OCRS[k] == 0 || OCRS[k] == 128 || OCRS[k] == 255) begin
            wr_ctl(1, 2, 1, 1'b0);
            wr_cmp(OCRS[k]);
            repeat (1100) @(negedge clk);
            wr_ctl(1, 2, 0, 1'b0);
            w1c(2'b11);
            wr_ctl(1, 2, 1, 1'b0);
            ev_count(1020, n_o, n_c);
            chk($sformatf("R11 pc cmp events ocr=%0d", OCRS[k]), n_c,
                (OCRS[k] == 0 || OCRS[k] == 255) ? 2 : 4);
            chk("R4 pc ovf events", n_o, 2);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule